// File: doc/BRIEF.md
# Slot Bus Configuration-Space Controller

This block is the responder for the controller card of a 32-slot system bus. The controller always sits in the last slot. Every slot owns a 64 KB window in a flat bus address space. The block watches the whole address range and claims two kinds of access. The first is any access to the window of a slot with no card in it, which it answers with a bus error. The second is any access to its own window. Accesses to the windows of populated slots are left for those cards to answer.

The lower 32 KB of the controller's window is split into 32 configuration regions of 1 KB, one per slot. Each region reports that slot's vendor, device and revision words, which come from the slot's identification inputs. The controller's own region reports fixed identifiers. It also holds three registers: a read-only RAM size, a read-only live mask of interrupting slots, and a power-off register that acts only on a magic value. The upper 32 KB of the window is where a boot ROM would be mapped. With no ROM fitted, that half answers with an error. Each access gets exactly one response, one cycle after the request.

Top module: `slotcfg_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `rsp_valid`, `rsp_err` and `pwr_off` are 0.
- R2: Address bits [20:16] select a slot window. In the controller window (slot 31), bits [14:10] select a configuration region and bits [9:0] the byte offset. A read at offset 0x000, 0x004 or 0x008 of region N < 31 returns slot N's vendor, device or revision input word with no error. A vendor word of 0 marks the slot as empty.
- R3: Region 31 reads vendor 1, device 1 and revision 1.
- R4: Reads of reserved offsets in any region return 0 with no error. Writes to them complete with no error and change nothing. Reserved offsets are 0x00C–0x3FF, except 0x200–0x208 in region 31.
- R5: Any access to the window of a slot (0–30) whose vendor word is 0 gets an error response. An access to a populated slot's window gets no response from this block.
- R6: Offset 0x200 of region 31 reads the RAM size parameter. A write to it gets an error response and changes no state.
- R7: Offset 0x204 of region 31 reads bit N = slot N's IRQ line, sampled through two synchroniser flops. A write to it gets an error response and changes nothing.
- R8: A write of exactly 0xFEE1DEAD to offset 0x208 of region 31 sets `pwr_off`. It stays high until reset. A write of any other value has no effect. Reads of that offset return 0 without error.
- R9: With no boot ROM fitted, any access to the upper half of the controller window (address bit 15 set) gets an error response.
- R10: A non-word-aligned access to the lower half of the controller window gets an error response and changes no state.
- R11: A write to a vendor, device or revision offset gets an error response.
- R12: Every claimed access is answered with `rsp_valid` in the cycle after `req`. `rsp_err` is only ever high together with `rsp_valid`. When there is no request, there is no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 21 | Byte address in the slot address space |
| wdata | input | 32 | Write data |
| slot_vid | input | 992 | Vendor words of slots 0–30, slot N at bits [32N+31:32N] |
| slot_did | input | 992 | Device words of slots 0–30, same packing |
| slot_rev | input | 992 | Revision words of slots 0–30, same packing |
| slot_irq | input | 32 | Asynchronous IRQ lines, bit N for slot N |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Error response, valid with `rsp_valid` |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` |
| pwr_off | output | 1 | Sticky power-off request |

## Verification
The hardest cases to reach are the ones where a near-miss on the power register must leave `pwr_off` low. These are the magic value written through a misaligned address, the magic value written to the RAM size offset, and a wrong value written to the right offset. The bench issues all three before the real magic write, then checks that `pwr_off` was still low before that write and became sticky after it. For the interrupt mask, the bench changes the IRQ lines and waits out both synchroniser stages. It then reads the mask, tries a write to it, and reads it again.

// File: rtl/slotcfg_pkg.sv
// Shared constants and access classification for the slot configuration controller.
package slotcfg_pkg;

    localparam int unsigned DATA_W = 32;
    localparam logic [DATA_W-1:0] PWR_MAGIC = 32'hFEE1_DEAD;
    localparam logic [DATA_W-1:0] CTRL_VENDOR = 32'd1;
    localparam logic [DATA_W-1:0] CTRL_DEVICE = 32'd1;
    localparam logic [DATA_W-1:0] CTRL_REVISION = 32'd1;

    // What an incoming access resolves to; ACC_NONE means not claimed.
    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_SLOT_ERR,
        ACC_ROM,
        ACC_MISALIGN,
        ACC_VID,
        ACC_DID,
        ACC_REV,
        ACC_RAMSZ,
        ACC_IRQS,
        ACC_PWR,
        ACC_RSVD
    } acc_kind_e;

endpackage

// File: rtl/slotcfg_decode.sv
// Address decoder: classifies an access from the address and slot presence.
// Assumes the controller occupies the highest slot, and that one window half
// holds exactly NSLOT regions (WIN_W - 1 == SLOT_W + REG_W).
module slotcfg_decode
    import slotcfg_pkg::*;
#(
    parameter int unsigned NSLOT      = 32,
    parameter int unsigned WIN_W      = 16,
    parameter bit          ROM_FITTED = 1'b0,
    parameter int unsigned SLOT_W     = $clog2(NSLOT),
    parameter int unsigned ADDR_W     = WIN_W + SLOT_W,
    parameter int unsigned REG_W      = WIN_W - 1 - SLOT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSLOT-1:0]  present,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] region
);

    localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(NSLOT - 1);
    localparam logic [REG_W-1:0]  OFF_VID   = REG_W'(32'h000);
    localparam logic [REG_W-1:0]  OFF_DID   = REG_W'(32'h004);
    localparam logic [REG_W-1:0]  OFF_REV   = REG_W'(32'h008);
    localparam logic [REG_W-1:0]  OFF_RAMSZ = REG_W'(32'h200);
    localparam logic [REG_W-1:0]  OFF_IRQS  = REG_W'(32'h204);
    localparam logic [REG_W-1:0]  OFF_PWR   = REG_W'(32'h208);

    logic [SLOT_W-1:0] slot;
    logic              rom_half;
    logic [REG_W-1:0]  offset;

    assign slot     = addr[WIN_W +: SLOT_W];
    assign rom_half = addr[WIN_W-1];
    assign region   = addr[REG_W +: SLOT_W];
    assign offset   = addr[REG_W-1:0];

    // Classify the access by window, half, alignment and offset.
    always_comb begin
        kind = ACC_RSVD;
        if (slot != CTRL_SLOT) begin
            kind = present[slot] ? ACC_NONE : ACC_SLOT_ERR;
        end else if (rom_half) begin
            kind = ROM_FITTED ? ACC_NONE : ACC_ROM;
        end else if (offset[1:0] != 2'b00) begin
            kind = ACC_MISALIGN;
        end else if (offset == OFF_VID) begin
            kind = ACC_VID;
        end else if (offset == OFF_DID) begin
            kind = ACC_DID;
        end else if (offset == OFF_REV) begin
            kind = ACC_REV;
        end else if (region == CTRL_SLOT && offset == OFF_RAMSZ) begin
            kind = ACC_RAMSZ;
        end else if (region == CTRL_SLOT && offset == OFF_IRQS) begin
            kind = ACC_IRQS;
        end else if (region == CTRL_SLOT && offset == OFF_PWR) begin
            kind = ACC_PWR;
        end
    end

endmodule

// File: rtl/slotcfg_idmux.sv
// Identification multiplexer: unpacks per-slot ID words, derives presence and
// selects one region's vendor/device/revision. The last region reports the
// controller's fixed identifiers.
module slotcfg_idmux
    import slotcfg_pkg::*;
#(
    parameter int unsigned NSLOT  = 32,
    parameter int unsigned SLOT_W = $clog2(NSLOT)
) (
    input  logic [(NSLOT-1)*DATA_W-1:0] slot_vid,
    input  logic [(NSLOT-1)*DATA_W-1:0] slot_did,
    input  logic [(NSLOT-1)*DATA_W-1:0] slot_rev,
    input  logic [SLOT_W-1:0]           region,
    output logic [NSLOT-1:0]            present,
    output logic [DATA_W-1:0]           sel_vid,
    output logic [DATA_W-1:0]           sel_did,
    output logic [DATA_W-1:0]           sel_rev
);

    logic [DATA_W-1:0] vid_arr [NSLOT];
    logic [DATA_W-1:0] did_arr [NSLOT];
    logic [DATA_W-1:0] rev_arr [NSLOT];

    // One entry per card slot; a zero vendor word means the slot is empty.
    for (genvar i = 0; i < NSLOT - 1; i++) begin : g_slot
        assign vid_arr[i] = slot_vid[i*DATA_W +: DATA_W];
        assign did_arr[i] = slot_did[i*DATA_W +: DATA_W];
        assign rev_arr[i] = slot_rev[i*DATA_W +: DATA_W];
        assign present[i] = |slot_vid[i*DATA_W +: DATA_W];
    end

    // The controller's own entry is constant and always present.
    assign vid_arr[NSLOT-1] = CTRL_VENDOR;
    assign did_arr[NSLOT-1] = CTRL_DEVICE;
    assign rev_arr[NSLOT-1] = CTRL_REVISION;
    assign present[NSLOT-1] = 1'b1;

    assign sel_vid = vid_arr[region];
    assign sel_did = did_arr[region];
    assign sel_rev = rev_arr[region];

endmodule

// File: rtl/slotcfg_irq_sync.sv
// Two-flop synchroniser for the asynchronous per-slot IRQ lines.
// Assumes each line is a level that holds until its device clears it.
module slotcfg_irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] irq_async,
    output logic [W-1:0] irq_sync
);

    logic [W-1:0] stage1;

    // Shift the raw lines through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            irq_sync <= '0;
        end else begin
            stage1   <= irq_async;
            irq_sync <= stage1;
        end
    end

endmodule

// File: rtl/slotcfg_pwr.sv
// Power-off latch: sets on a write of the magic word and holds until reset.
module slotcfg_pwr
    import slotcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              pwr_off
);

    // Latch the request only when the exact magic word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_off <= 1'b0;
        end else if (wr_en && wdata == PWR_MAGIC) begin
            pwr_off <= 1'b1;
        end
    end

endmodule

// File: rtl/slotcfg_ctrl.sv
// Slot bus configuration-space controller (top).
// Claims accesses to empty slot windows and to its own window, and answers
// each claimed access one cycle after the request. Assumes single-cycle
// requests, with no back-pressure.
module slotcfg_ctrl
    import slotcfg_pkg::*;
#(
    parameter int unsigned NSLOT      = 32,
    parameter int unsigned WIN_W      = 16,
    parameter bit          ROM_FITTED = 1'b0,
    parameter logic [31:0] RAM_BYTES  = 32'h0100_0000,
    parameter int unsigned ADDR_W     = WIN_W + $clog2(NSLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    input  logic [(NSLOT-1)*32-1:0]     slot_vid,
    input  logic [(NSLOT-1)*32-1:0]     slot_did,
    input  logic [(NSLOT-1)*32-1:0]     slot_rev,
    input  logic [NSLOT-1:0]            slot_irq,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [31:0]                 rsp_rdata,
    output logic                        pwr_off
);

    localparam int unsigned SLOT_W = $clog2(NSLOT);

    acc_kind_e         kind;
    logic [SLOT_W-1:0] region;
    logic [NSLOT-1:0]  present;
    logic [31:0]       sel_vid;
    logic [31:0]       sel_did;
    logic [31:0]       sel_rev;
    logic [NSLOT-1:0]  irq_now;
    logic              nxt_err;
    logic [31:0]       nxt_rdata;

    slotcfg_decode #(
        .NSLOT      (NSLOT),
        .WIN_W      (WIN_W),
        .ROM_FITTED (ROM_FITTED)
    ) u_decode (
        .addr    (addr),
        .present (present),
        .kind    (kind),
        .region  (region)
    );

    slotcfg_idmux #(
        .NSLOT (NSLOT)
    ) u_idmux (
        .slot_vid (slot_vid),
        .slot_did (slot_did),
        .slot_rev (slot_rev),
        .region   (region),
        .present  (present),
        .sel_vid  (sel_vid),
        .sel_did  (sel_did),
        .sel_rev  (sel_rev)
    );

    slotcfg_irq_sync #(
        .W (NSLOT)
    ) u_irq_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_async (slot_irq),
        .irq_sync  (irq_now)
    );

    slotcfg_pwr u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req && we && kind == ACC_PWR),
        .wdata   (wdata),
        .pwr_off (pwr_off)
    );

    // Work out the error flag and read data for the current access.
    always_comb begin
        nxt_err   = 1'b0;
        nxt_rdata = '0;
        unique case (kind)
            ACC_SLOT_ERR, ACC_ROM, ACC_MISALIGN: nxt_err = 1'b1;
            ACC_VID:   begin nxt_err = we; nxt_rdata = sel_vid;   end
            ACC_DID:   begin nxt_err = we; nxt_rdata = sel_did;   end
            ACC_REV:   begin nxt_err = we; nxt_rdata = sel_rev;   end
            ACC_RAMSZ: begin nxt_err = we; nxt_rdata = RAM_BYTES; end
            ACC_IRQS:  begin nxt_err = we; nxt_rdata = 32'(irq_now); end
            default:   begin nxt_err = 1'b0; nxt_rdata = '0; end
        endcase
        if (we || nxt_err) begin
            nxt_rdata = '0;
        end
    end

    // Register the response one cycle after a claimed request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req && kind != ACC_NONE;
            rsp_err   <= req && kind != ACC_NONE && nxt_err;
            rsp_rdata <= (req && kind != ACC_NONE) ? nxt_rdata : '0;
        end
    end

endmodule

// File: rtl/slotcfg_ctrl_chk.sv
// Protocol checker for slotcfg_ctrl, attached to every instance by bind.
module slotcfg_ctrl_chk #(
    parameter int unsigned NSLOT      = 32,
    parameter int unsigned WIN_W      = 16,
    parameter bit          ROM_FITTED = 1'b0,
    parameter int unsigned ADDR_W     = WIN_W + $clog2(NSLOT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              pwr_off
);

    localparam int unsigned SLOT_W = $clog2(NSLOT);
    localparam int unsigned REG_W  = WIN_W - 1 - SLOT_W;
    localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(NSLOT - 1);
    localparam int unsigned CFG_BASE = (NSLOT - 1) * (2 ** WIN_W) + (NSLOT - 1) * (2 ** REG_W);
    localparam logic [ADDR_W-1:0] A_RAMSZ = ADDR_W'(CFG_BASE + 32'h200);
    localparam logic [ADDR_W-1:0] A_IRQS  = ADDR_W'(CFG_BASE + 32'h204);
    localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(CFG_BASE + 32'h208);

    logic in_ctrl;
    assign in_ctrl = addr[WIN_W +: SLOT_W] == CTRL_SLOT;

    p_no_req_no_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    p_ctrl_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req && in_ctrl && !(ROM_FITTED && addr[WIN_W-1]) |=> rsp_valid);
    p_err_with_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    p_rom_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req && in_ctrl && addr[WIN_W-1] && !ROM_FITTED |=> rsp_err);
    p_misalign_error_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req && in_ctrl && addr[1:0] != 2'b00 |=> rsp_err);
    p_ramsz_write_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && addr == A_RAMSZ |=> rsp_err);
    p_irqs_write_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && addr == A_IRQS |=> rsp_err);
    p_pwr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> pwr_off);
    p_pwr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off) |-> $past(req && we && addr == A_PWR && wdata == 32'hFEE1_DEAD));

endmodule

bind slotcfg_ctrl slotcfg_ctrl_chk #(
    .NSLOT      (NSLOT),
    .WIN_W      (WIN_W),
    .ROM_FITTED (ROM_FITTED),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .pwr_off   (pwr_off)
);

// File: tb/slotcfg_ctrl_test.sv
// Directed bench for slotcfg_ctrl: one task per scenario.
module slotcfg_ctrl_test;

    localparam logic [31:0] RAM_SIZE = 32'h0100_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [20:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [991:0]  slot_vid;
    logic [991:0]  slot_did;
    logic [991:0]  slot_rev;
    logic [31:0]   slot_irq = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic          pwr_off;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    slotcfg_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .slot_vid  (slot_vid),
        .slot_did  (slot_did),
        .slot_rev  (slot_rev),
        .slot_irq  (slot_irq),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .pwr_off   (pwr_off)
    );

    // Even slots hold cards, odd slots are empty but carry garbage IDs.
    initial begin
        for (int i = 0; i < 31; i++) begin
            slot_vid[i*32 +: 32] = (i % 2 == 0) ? 32'h100 + i : 32'h0;
            slot_did[i*32 +: 32] = 32'h2000 + i;
            slot_rev[i*32 +: 32] = 32'h30 + i;
        end
    end

    function automatic logic [20:0] cfg(input int region, input int off);
        return 21'(31 * 65536 + region * 1024 + off);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [20:0] a, input logic [31:0] d,
                          output logic v, output logic e, output logic [31:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        v = rsp_valid; e = rsp_err; r = rsp_rdata;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(rsp_valid), 0);
        check("R1 err in reset", 32'(rsp_err), 0);
        check("R1 pwr_off in reset", 32'(pwr_off), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(rsp_valid), 0);
        check("R1 pwr_off after reset", 32'(pwr_off), 0);
    endtask

    task automatic t_slot_ids;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(4, 0), 0, v, e, r);
        check("R2 slot4 vid", r, 32'h104); check("R2 slot4 vid err", 32'(e), 0);
        check("R12 slot4 valid", 32'(v), 1);
        access(1'b0, cfg(4, 4), 0, v, e, r);  check("R2 slot4 did", r, 32'h2004);
        access(1'b0, cfg(30, 8), 0, v, e, r); check("R2 slot30 rev", r, 32'h4E);
        access(1'b0, cfg(3, 0), 0, v, e, r);  check("R2 empty slot3 vid", r, 0);
        check("R2 empty slot3 region err", 32'(e), 0);
    endtask

    task automatic t_ctrl_ids;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(31, 0), 0, v, e, r); check("R3 ctrl vid", r, 1);
        access(1'b0, cfg(31, 4), 0, v, e, r); check("R3 ctrl did", r, 1);
        access(1'b0, cfg(31, 8), 0, v, e, r); check("R3 ctrl rev", r, 1);
    endtask

    task automatic t_reserved;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(2, 12), 0, v, e, r);
        check("R4 rsvd 0x00C data", r, 0); check("R4 rsvd 0x00C err", 32'(e), 0);
        access(1'b0, cfg(2, 'h200), 0, v, e, r); check("R4 slot2 0x200 data", r, 0);
        access(1'b0, cfg(31, 'h20C), 0, v, e, r); check("R4 ctrl 0x20C data", r, 0);
        access(1'b1, cfg(31, 'h3FC), 32'hFFFF_FFFF, v, e, r);
        check("R4 rsvd write err", 32'(e), 0); check("R4 rsvd write valid", 32'(v), 1);
        access(1'b0, cfg(31, 'h3FC), 0, v, e, r); check("R4 rsvd after write", r, 0);
    endtask

    task automatic t_windows;
        logic v, e; logic [31:0] r;
        access(1'b0, 21'(1 * 65536 + 'h40), 0, v, e, r);
        check("R5 empty slot1 valid", 32'(v), 1); check("R5 empty slot1 err", 32'(e), 1);
        access(1'b1, 21'(29 * 65536 + 'h8000), 32'h5, v, e, r);
        check("R5 empty slot29 write err", 32'(e), 1);
        access(1'b0, 21'(2 * 65536 + 'h40), 0, v, e, r);
        check("R5 present slot2 unclaimed", 32'(v), 0);
        access(1'b1, 21'(0 * 65536 + 'h3), 0, v, e, r);
        check("R5 present slot0 unclaimed", 32'(v), 0);
    endtask

    task automatic t_ramsz;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(31, 'h200), 0, v, e, r);
        check("R6 ramsz read", r, RAM_SIZE); check("R6 ramsz read err", 32'(e), 0);
        access(1'b1, cfg(31, 'h200), 32'h1234, v, e, r); check("R6 ramsz write err", 32'(e), 1);
        access(1'b0, cfg(31, 'h200), 0, v, e, r); check("R6 ramsz unchanged", r, RAM_SIZE);
    endtask

    task automatic t_irqs;
        logic v, e; logic [31:0] r;
        slot_irq = 32'h8000_0021;
        repeat (3) @(negedge clk);
        access(1'b0, cfg(31, 'h204), 0, v, e, r); check("R7 irqs mask A", r, 32'h8000_0021);
        access(1'b1, cfg(31, 'h204), 32'h0, v, e, r); check("R7 irqs write err", 32'(e), 1);
        access(1'b0, cfg(31, 'h204), 0, v, e, r); check("R7 irqs after write", r, 32'h8000_0021);
        slot_irq = 32'h0000_4000;
        repeat (3) @(negedge clk);
        access(1'b0, cfg(31, 'h204), 0, v, e, r); check("R7 irqs mask B", r, 32'h0000_4000);
        slot_irq = '0;
    endtask

    task automatic t_rom;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(0, 'h8000), 0, v, e, r);
        check("R9 rom read valid", 32'(v), 1); check("R9 rom read err", 32'(e), 1);
        access(1'b1, 21'(31 * 65536 + 'hFFFC), 32'h1, v, e, r); check("R9 rom write err", 32'(e), 1);
    endtask

    task automatic t_misalign_idwrite;
        logic v, e; logic [31:0] r;
        access(1'b0, cfg(4, 1), 0, v, e, r); check("R10 misaligned read err", 32'(e), 1);
        check("R10 misaligned read data", r, 0);
        access(1'b1, cfg(4, 0), 32'h9, v, e, r); check("R11 vid write err", 32'(e), 1);
        access(1'b1, cfg(31, 8), 32'h9, v, e, r); check("R11 ctrl rev write err", 32'(e), 1);
        access(1'b0, cfg(31, 8), 0, v, e, r); check("R11 ctrl rev unchanged", r, 1);
    endtask

    task automatic t_power;
        logic v, e; logic [31:0] r;
        access(1'b1, cfg(31, 'h208), 32'hFEE1_DEAC, v, e, r);
        check("R8 wrong value err", 32'(e), 0); check("R8 wrong value no pwr", 32'(pwr_off), 0);
        access(1'b1, cfg(31, 'h20A), 32'hFEE1_DEAD, v, e, r);
        check("R10 misaligned magic err", 32'(e), 1); check("R10 misaligned magic no pwr", 32'(pwr_off), 0);
        access(1'b1, cfg(31, 'h200), 32'hFEE1_DEAD, v, e, r);
        check("R6 magic to ramsz no pwr", 32'(pwr_off), 0);
        access(1'b0, cfg(31, 'h208), 0, v, e, r);
        check("R8 pwr read zero", r, 0); check("R8 pwr read err", 32'(e), 0);
        access(1'b1, cfg(31, 'h208), 32'hFEE1_DEAD, v, e, r);
        check("R8 magic sets pwr", 32'(pwr_off), 1);
        access(1'b1, cfg(31, 'h208), 32'h0, v, e, r);
        repeat (4) @(negedge clk);
        check("R8 pwr sticky", 32'(pwr_off), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 pwr cleared by reset", 32'(pwr_off), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        t_slot_ids();
        t_ctrl_ids();
        t_reserved();
        t_windows();
        t_ramsz();
        t_irqs();
        t_rom();
        t_misalign_idwrite();
        t_power();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule